// File: doc/BRIEF.md
# Dual-Line Serial Audio Receiver with Silence Mute

This block takes stereo audio that arrives as two serial data lines, one for the left channel and one for the right. Both lines share a bit clock and a word clock. All of these inputs are sampled in the system clock domain. On each rising bit clock edge both channels shift in one bit, most significant bit first. When the word clock falls, the bits collected so far are turned into a parallel sample pair, and a one-cycle valid strobe marks the new pair. A quasi-static select input picks a full-width word or a shorter word. A short word is left-aligned and zero-filled at the bottom.

The receiver also drives a mute flag for the output stage that follows. The flag rises in two cases: the received pair has repeated itself for a long, parameterised run of words, or the word clock has shown no edge for a parameterised number of system clocks. If the bit clock stops while the word clock keeps running, the shift registers freeze. Every latched pair then repeats, so the repeat rule catches that case as well. The flag drops on the first latched pair that differs from the one before it.

Top module: `aud_ser_rx`

## Requirements
- R1: While reset is applied and until the first latched word after it, both sample outputs read zero and valid is low. Mute is high from reset onward.
- R2: A bit is taken from each data line on every rising bit clock edge, most significant bit first. On a falling word clock edge, each channel output with the select high takes the last SAMPLE_W bits shifted in. The two channels are independent and are latched together.
- R3: Each falling word clock edge gives exactly one valid pulse, one system clock long, on the third rising system clock edge after the fall is first sampled. A rising word clock edge gives no pulse. Between pulses the sample outputs do not change.
- R4: With the select low (value 0), each output carries the last SHORT_W bits shifted in, in bit positions SAMPLE_W-1 down to SAMPLE_W-SHORT_W. The lower SAMPLE_W-SHORT_W bits are zero, and bits shifted in before those SHORT_W bits are ignored.
- R5: The bit clock may pause for any length of time between bits. A word delivered in bursts latches the same value as one delivered with a steady clock.
- R6: Mute goes high on the latch of the QUIET_RUN-th consecutive pair that equals the pair latched before it. This also happens when a stopped bit clock leaves the latched pairs unchanged.
- R7: Mute goes high once LOSS_CYCLES system clocks pass with no edge of either polarity on the synchronised word clock.
- R8: Mute goes low only on the latch of a pair that differs from the previously latched pair. A pair counts as differing if either channel differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk_i | input | 1 | Serial bit clock, may be gated |
| wclk_i | input | 1 | Word clock; falling edge latches a word |
| ldata_i | input | 1 | Left channel serial data, MSB first, two's complement |
| rdata_i | input | 1 | Right channel serial data, MSB first, two's complement |
| sel24_i | input | 1 | Word length select: 1 full width, 0 short width |
| left_o | output | SAMPLE_W | Latched left sample |
| right_o | output | SAMPLE_W | Latched right sample |
| valid_o | output | 1 | One-cycle strobe on a new sample pair |
| mute_o | output | 1 | Auto-mute flag |

## Verification
The bench keeps the default sample widths of 24 and 20 bits. It lowers QUIET_RUN to 4 and LOSS_CYCLES to 200. These values put the repeat rule and the lost-clock rule a few frames away instead of thousands of words. The set, hold and release of mute can then be walked through edge by edge alongside wide data, short data, negative values and bursts of the bit clock.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic {
    SEL_SHORT = 1'b0,
    SEL_FULL  = 1'b1
  } word_len_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [N-1:0][W-1:0] st_q, st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int i = 1; i < int'(N); i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[N-1];
endmodule

// File: rtl/asr_chan_shift.sv
module asr_chan_shift #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SHORT_W  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_i,
  input  logic                latch_en,
  input  logic                full_sel,
  output logic [SAMPLE_W-1:0] word_o,
  output logic [SAMPLE_W-1:0] word_next_o
);
  localparam int unsigned PAD_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] sr_q, sr_d, word_q, word_d, short_word;

  generate
    if (PAD_W > 0) begin : g_pad
      assign short_word = {sr_q[SHORT_W-1:0], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign short_word = sr_q;
    end
  endgenerate

  always_comb begin
    sr_d   = sr_q;
    word_d = word_q;
    if (shift_en) sr_d = {sr_q[SAMPLE_W-2:0], bit_i};
    if (latch_en) word_d = full_sel ? sr_q : short_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      word_q <= '0;
    end else begin
      sr_q   <= sr_d;
      word_q <= word_d;
    end
  end

  assign word_o      = word_q;
  assign word_next_o = word_d;
endmodule

// File: rtl/asr_mute_ctl.sv
module asr_mute_ctl #(
  parameter int unsigned PAIR_W      = 48,
  parameter int unsigned QUIET_RUN   = 8192,
  parameter int unsigned LOSS_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic              wclk_edge,
  input  logic [PAIR_W-1:0] cand_i,
  input  logic [PAIR_W-1:0] prev_i,
  output logic              mute_o
);
  localparam int unsigned RUN_W  = $clog2(QUIET_RUN + 1);
  localparam int unsigned IDLE_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(QUIET_RUN);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(LOSS_CYCLES);

  logic [RUN_W-1:0]  run_q, run_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              mute_q, mute_d, same;

  assign same = (cand_i == prev_i);

  always_comb begin
    run_d  = run_q;
    idle_d = idle_q;
    mute_d = mute_q;
    if (latch_en) begin
      if (same) begin
        if (run_q != RUN_MAX) run_d = run_q + 1'b1;
      end else begin
        run_d = '0;
      end
      if (!same) mute_d = 1'b0;
      else if (run_d == RUN_MAX) mute_d = 1'b1;
    end
    if (wclk_edge) idle_d = '0;
    else if (idle_q != IDLE_MAX) idle_d = idle_q + 1'b1;
    if (idle_d == IDLE_MAX) mute_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      idle_q <= '0;
      mute_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      idle_q <= idle_d;
      mute_q <= mute_d;
    end
  end

  assign mute_o = mute_q;
endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
  import asr_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned SHORT_W     = 20,
  parameter int unsigned QUIET_RUN   = 8192,
  parameter int unsigned LOSS_CYCLES = 65536
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                ldata_i,
  input  logic                rdata_i,
  input  logic                sel24_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o,
  output logic                mute_o
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned PAIR_W = NCH * SAMPLE_W;

  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  // Index 0 bit clock, 1 word clock, 2 left data, 3 right data.
  logic [3:0] sync_q;
  asr_sync #(.W(4), .N(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   ({rdata_i, ldata_i, wclk_i, bclk_i}),
    .q_o   (sync_q)
  );

  logic [1:0] clk_prev_q, clk_prev_d;
  logic       bclk_rise, wclk_fall, wclk_edge, full_sel;
  logic       valid_q, valid_d;

  assign clk_prev_d = sync_q[1:0];
  assign bclk_rise  = sync_q[0] & ~clk_prev_q[0];
  assign wclk_fall  = ~sync_q[1] & clk_prev_q[1];
  assign wclk_edge  = sync_q[1] ^ clk_prev_q[1];
  assign valid_d    = wclk_fall;
  assign full_sel   = (word_len_e'(sel24_i) == SEL_FULL);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      clk_prev_q <= '0;
      valid_q    <= 1'b0;
    end else begin
      clk_prev_q <= clk_prev_d;
      valid_q    <= valid_d;
    end
  end

  logic [NCH-1:0][SAMPLE_W-1:0] word_q, word_n;

  generate
    for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
      asr_chan_shift #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_ch (
        .clk         (clk),
        .rst_n       (core_rst_n),
        .shift_en    (bclk_rise),
        .bit_i       (sync_q[2+g]),
        .latch_en    (wclk_fall),
        .full_sel    (full_sel),
        .word_o      (word_q[g]),
        .word_next_o (word_n[g])
      );
    end
  endgenerate

  asr_mute_ctl #(
    .PAIR_W      (PAIR_W),
    .QUIET_RUN   (QUIET_RUN),
    .LOSS_CYCLES (LOSS_CYCLES)
  ) u_mute (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .latch_en  (wclk_fall),
    .wclk_edge (wclk_edge),
    .cand_i    (word_n),
    .prev_i    (word_q),
    .mute_o    (mute_o)
  );

  assign left_o  = word_q[0];
  assign right_o = word_q[1];
  assign valid_o = valid_q;
endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SHORT_W  = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sel24_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o,
  input logic                mute_o
);
  localparam int unsigned PAD_W = SAMPLE_W - SHORT_W;

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  assert_short_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !$past(sel24_i)) |->
      (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));

  assert_release_on_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> valid_o);
endmodule

bind aud_ser_rx aud_ser_rx_chk #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel24_i (sel24_i),
  .left_o  (left_o),
  .right_o (right_o),
  .valid_o (valid_o),
  .mute_o  (mute_o)
);

// File: tb/aud_ser_rx_bench.sv
module aud_ser_rx_bench;
  localparam int SW    = 24;
  localparam int QUIET = 4;
  localparam int LOSS  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, ldat = 1'b0, rdat = 1'b0, sel24 = 1'b1;
  logic [SW-1:0] left, right;
  logic valid, mute;

  always #10 clk = ~clk;

  aud_ser_rx #(.SAMPLE_W(SW), .SHORT_W(20), .QUIET_RUN(QUIET), .LOSS_CYCLES(LOSS))
  u_aud_ser_rx (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .ldata_i(ldat),
    .rdata_i(rdat), .sel24_i(sel24), .left_o(left), .right_o(right),
    .valid_o(valid), .mute_o(mute)
  );

  int vectors = 0, errors = 0, valid_seen = 0;
  bit done = 0, model_live = 0;

  // Behavioural reference model, stepped on every rising clock edge.
  logic [3:0] h0 = '0, h1 = '0, h2 = '0;
  logic [SW-1:0] m_srl = '0, m_srr = '0, m_l = '0, m_r = '0;
  logic m_valid = 0, m_mute = 1;
  int rc = 0, run = 0, idle = 0;

  task automatic model_reset();
    h0 = '0; h1 = '0; h2 = '0;
    m_srl = '0; m_srr = '0; m_l = '0; m_r = '0;
    m_valid = 0; m_mute = 1; run = 0; idle = 0;
  endtask

  always @(posedge clk) begin
    model_live <= 1;
    if (!rst_n) begin rc = 0; model_reset(); end
    else if (rc < 2) begin rc++; model_reset(); end
    else begin
      logic b_r, w_f, w_e, same;
      logic [SW-1:0] nl, nr;
      b_r = h1[0] && !h2[0];
      w_f = !h1[1] && h2[1];
      w_e = h1[1] != h2[1];
      if (w_f) begin
        nl = sel24 ? m_srl : {m_srl[19:0], 4'b0};
        nr = sel24 ? m_srr : {m_srr[19:0], 4'b0};
        same = (nl == m_l) && (nr == m_r);
        if (same) begin if (run < QUIET) run++; end else run = 0;
        if (!same) m_mute = 0;
        else if (run == QUIET) m_mute = 1;
        m_l = nl; m_r = nr;
      end
      if (w_e) idle = 0; else if (idle < LOSS) idle++;
      if (idle == LOSS) m_mute = 1;
      m_valid = w_f;
      if (b_r) begin
        m_srl = {m_srl[SW-2:0], h1[2]};
        m_srr = {m_srr[SW-2:0], h1[3]};
      end
      h2 = h1; h1 = h0; h0 = {rdat, ldat, wclk, bclk};
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (model_live && !done) begin
      check("R2 R4 left model", 32'(left), 32'(m_l));
      check("R2 R4 right model", 32'(right), 32'(m_r));
      check("R3 valid model", 32'(valid), 32'(m_valid));
      check("R6 R7 R8 mute model", 32'(mute), 32'(m_mute));
      if (valid) valid_seen++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One frame: 32 bit slots, word in the last nb slots, leading filler of ones.
  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r, input int nb, input int gap);
    for (int i = 0; i < 32; i++) begin
      int k;
      k = i - (32 - nb);
      bclk = 0;
      ldat = (k >= 0) ? l[nb-1-k] : 1'b1;
      rdat = (k >= 0) ? r[nb-1-k] : 1'b1;
      if (i == 16) wclk = 1;
      wait_cyc(2);
      if (i == 20) wait_cyc(gap);
      bclk = 1;
      wait_cyc(2);
    end
    bclk = 0;
    wclk = 0;
    wait_cyc(8);
  endtask

  task automatic wclk_only();
    wait_cyc(40);
    wclk = 1;
    wait_cyc(40);
    wclk = 0;
    wait_cyc(8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    vectors++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int v0;
    wait_cyc(5);
    check("R1 left in reset", 32'(left), 0);
    check("R1 valid in reset", 32'(valid), 0);
    check("R1 mute in reset", 32'(mute), 1);
    rst_n = 1;
    wait_cyc(10);
    check("R1 mute after reset", 32'(mute), 1);
    check("R1 right after reset", 32'(right), 0);

    v0 = valid_seen;
    send(24'h123456, 24'hABCDEF, 24, 0);
    check("R2 left word", 32'(left), 32'h123456);
    check("R2 right word", 32'(right), 32'hABCDEF);
    check("R3 one pulse per frame", 32'(valid_seen - v0), 1);
    check("R8 release on new word", 32'(mute), 0);

    send(24'h800001, 24'h7FFFFF, 24, 0);
    check("R2 negative left", 32'(left), 32'h800001);
    check("R2 positive right", 32'(right), 32'h7FFFFF);

    send(24'h5A5A5A, 24'hC3C3C3, 24, 50);
    check("R5 burst left", 32'(left), 32'h5A5A5A);
    check("R5 burst right", 32'(right), 32'hC3C3C3);

    sel24 = 0;
    send(24'h0ABCDE, 24'h080001, 20, 0);
    check("R4 short left", 32'(left), 32'hABCDE0);
    check("R4 short right", 32'(right), 32'h800010);
    sel24 = 1;

    send(24'h010203, 24'h040506, 24, 0);
    check("R8 mute low before run", 32'(mute), 0);
    for (int i = 0; i < QUIET - 1; i++) send(24'h010203, 24'h040506, 24, 0);
    check("R6 mute low one short of run", 32'(mute), 0);
    send(24'h010203, 24'h040506, 24, 0);
    check("R6 mute high after run", 32'(mute), 1);

    send(24'h010203, 24'h040507, 24, 0);
    check("R8 release on right change", 32'(mute), 0);

    wait_cyc(150);
    check("R7 mute low before timeout", 32'(mute), 0);
    wait_cyc(60);
    check("R7 mute high after timeout", 32'(mute), 1);

    send(24'hFEDCBA, 24'h000001, 24, 0);
    check("R8 release after clock returns", 32'(mute), 0);

    for (int i = 0; i < QUIET; i++) wclk_only();
    check("R6 stopped bit clock mutes", 32'(mute), 1);
    check("R2 frozen word held", 32'(left), 32'hFEDCBA);

    wait_cyc(5);
    finish_run();
  end
endmodule